// File: doc/BRIEF.md
# Memory Bank Interrupt Detector and Status Register

This block is the status and interrupt register for one external memory bank. It watches the bank's interrupt pin, which arrives asynchronously from the memory device. It can report three kinds of event: a rising edge, a high level and a falling edge. Each kind has its own enable bit and its own sticky status flag. Software reads the flags, the enables and a live write-buffer-empty indication through one 32-bit register. It clears flags by writing zeros to them.

The write buffer sits in front of the bank and holds up to 16 words. It reports its current occupancy to this block. The empty bit reads 1 only when no word is left to drain, so software can poll it before it reads anything that depends on all data having reached the memory. A single interrupt request output is raised while any enabled flag is set.

Top module: `bankirq_status`

## Requirements
- R1: After reset the register reads 0x0000_0040 and `irq_out` is 0.
- R2: Bit 6 reads 1 when `fifo_level` was 0 at the previous clock edge, and 0 when it was any value from 1 to 16. Bit 6 reads 1 after reset.
- R3: Bit 3 (rising-edge enable), bit 4 (high-level enable) and bit 5 (falling-edge enable) take the written value on every register write and read back unchanged. 1 means enabled.
- R4: A low-to-high change of `irq_pin` sets bit 0 on the third clock edge after the change, provided bit 3 is 1. Two of those edges are the two synchronizer flops.
- R5: While the synchronized pin is high and bit 4 is 1, bit 1 is set.
- R6: A high-to-low change of `irq_pin` sets bit 2 on the third clock edge after the change, provided bit 5 is 1.
- R7: A set flag stays set after its condition ends. It clears only when a register write carries 0 in that bit position. Writing 1 to a flag bit leaves it unchanged.
- R8: A flag whose enable bit is 0 is never set by its condition. Clearing works whatever the enable is.
- R9: `irq_out` is 1 exactly when some flag in bits 0 to 2 is 1 and the enable bit three positions above it is also 1.
- R10: When a flag's set condition and a write of 0 to that flag fall in the same cycle, the flag ends the cycle set.
- R11: Writes to bit 6 and to bits 31 to 7 have no effect. Bits 31 to 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq_pin | input | 1 | Asynchronous interrupt pin from the memory device |
| fifo_level | input | 5 | Number of words waiting in the bank write buffer (0 to 16) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench sweeps all eight enable combinations through a full pin pulse. A detector wired to the wrong flag, or one that ignores its enable, leaves a wrong bit set, and so does a design that catches edges before synchronization. The bench clears flags while the pin is still high. A design where the clear beats the detection loses the high-level flag in that case. The bench also writes ones to set flags, to bit 6 and to the reserved bits. A design that toggles flags, or stores bit 6 or the upper bits, shows a changed read value. Every buffer occupancy from 0 to 16 is applied, and an empty comparison that only tests the low bits reports empty at 16.

// File: rtl/bankirq_pkg.sv
package bankirq_pkg;

  localparam int unsigned NKIND     = 3;
  localparam int unsigned FLAG_LSB  = 0;
  localparam int unsigned EN_LSB    = 3;
  localparam int unsigned EMPTY_BIT = 6;
  localparam int unsigned REG_W     = 32;

  typedef enum logic [1:0] {
    KIND_RISE = 2'd0,
    KIND_HIGH = 2'd1,
    KIND_FALL = 2'd2
  } kind_e;

  // Event of one detector kind from the current and previous synchronized samples
  function automatic logic kind_event(input int unsigned kind, input logic cur, input logic prev);
    logic r;
    case (kind)
      0:       r = cur & ~prev;
      1:       r = cur;
      default: r = ~cur & prev;
    endcase
    return r;
  endfunction

  // Next value of a sticky flag: set wins over clear
  function automatic logic flag_next(input logic q, input logic set_i, input logic clr_i);
    logic r;
    if (set_i)      r = 1'b1;
    else if (clr_i) r = 1'b0;
    else            r = q;
    return r;
  endfunction

endpackage

// File: rtl/bankirq_sync.sv
module bankirq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bankirq_detect.sv
module bankirq_detect
  import bankirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_sync,
  output logic [NKIND-1:0] evt_raw
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_sync;
  end

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    assign evt_raw[k] = kind_event(k, pin_sync, prev_q);
  end
endmodule

// File: rtl/bankirq_flags.sv
module bankirq_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flag_next_bit(flags_q[i], set_i[i], clr_i[i]);
    end
  end

  function automatic logic flag_next_bit(input logic q, input logic s, input logic c);
    return bankirq_pkg::flag_next(q, s, c);
  endfunction

  assign flags_o = flags_q;
endmodule

// File: rtl/bankirq_status.sv
module bankirq_status
  import bankirq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             irq_pin,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             irq_out
);
  logic             pin_sync;
  logic [NKIND-1:0] evt_raw;
  logic [NKIND-1:0] evt_set;
  logic [NKIND-1:0] clr_req;
  logic [NKIND-1:0] flags;
  logic [NKIND-1:0] en_q;
  logic             empty_q;

  bankirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(irq_pin), .sync_o(pin_sync)
  );

  bankirq_detect u_detect (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .evt_raw(evt_raw)
  );

  assign evt_set = evt_raw & en_q;
  assign clr_req = {NKIND{reg_wr}} & ~reg_wdata[FLAG_LSB +: NKIND];

  bankirq_flags #(.N(NKIND)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set), .clr_i(clr_req), .flags_o(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      empty_q <= 1'b1;
    end else begin
      if (reg_wr) en_q <= reg_wdata[EN_LSB +: NKIND];
      empty_q <= (fifo_level == '0);
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[FLAG_LSB +: NKIND] = flags;
    reg_rdata[EN_LSB +: NKIND]   = en_q;
    reg_rdata[EMPTY_BIT]         = empty_q;
  end

  assign irq_out = |(flags & en_q);
endmodule

// File: rtl/bankirq_status_chk.sv
module bankirq_status_chk #(
  parameter int unsigned LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       wr_flags,
  input logic [31:0]      reg_rdata,
  input logic [LVL_W-1:0] fifo_level,
  input logic             irq_out,
  input logic [2:0]       evt_set
);
  // R2
  p_empty_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == '0) |=> reg_rdata[6]);
  p_nonempty_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level != '0) |=> !reg_rdata[6]);
  // R7
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && !(reg_wr && !wr_flags[0])) |=> reg_rdata[0]);
  // R8
  p_no_set_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[1] && !reg_rdata[4]) |=> !reg_rdata[1]);
  // R9
  p_irq_combine_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(reg_rdata[2:0] & reg_rdata[5:3]));
  // R10
  p_detect_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set[1] && reg_wr && !wr_flags[1]) |=> reg_rdata[1]);
  // R11
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:7] == '0);
endmodule

bind bankirq_status bankirq_status_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_flags(reg_wdata[2:0]),
  .reg_rdata(reg_rdata), .fifo_level(fifo_level), .irq_out(irq_out),
  .evt_set(evt_set)
);

// File: tb/bankirq_status_test.sv
module bankirq_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_pin = 1'b0;
  logic [4:0]  fifo_level = '0;
  logic        irq_out;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  bankirq_status uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_pin(irq_pin), .fifo_level(fifo_level),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] regval(input logic [2:0] en, input logic [2:0] fl, input logic emp);
    return {25'd0, emp, en, fl};
  endfunction

  initial begin
    wait_cyc(3);
    // R1
    check("R1 reset value", reg_rdata, 32'h40);
    check("R1 irq reset", {31'd0, irq_out}, 32'd0);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R1 after release", reg_rdata, 32'h40);

    // R2: occupancy sweep
    for (int lvl = 0; lvl <= 16; lvl++) begin
      fifo_level = lvl[4:0];
      wait_cyc(1);
      check("R2 empty bit", {31'd0, reg_rdata[6]}, {31'd0, (lvl == 0)});
    end
    fifo_level = 5'd16;
    wait_cyc(1);

    // Enable sweep with a full pin pulse: R3 R4 R5 R6 R7 R8 R9 R10
    for (int e = 0; e < 8; e++) begin
      logic [2:0] en;
      logic [2:0] fl;
      en = e[2:0];
      wr({26'd0, en, 3'b000});
      check("R3 enable readback", reg_rdata, regval(en, 3'b000, 1'b0));
      irq_pin = 1'b1;
      wait_cyc(2);
      // two edges after the change: synchronizer still filling, nothing set (R4)
      check("R4 no early set", reg_rdata, regval(en, 3'b000, 1'b0));
      wait_cyc(1);
      fl = {1'b0, en[1], en[0]};
      check("R4 R5 R8 after rise", reg_rdata, regval(en, fl, 1'b0));
      check("R9 irq after rise", {31'd0, irq_out}, {31'd0, |(fl & en)});
      // clear everything while the pin stays high: high-level detection wins (R10)
      wr({26'd0, en, 3'b000});
      fl = {1'b0, en[1], 1'b0};
      check("R10 detect beats clear", reg_rdata, regval(en, fl, 1'b0));
      irq_pin = 1'b0;
      wait_cyc(4);
      fl = {en[2], en[1], 1'b0};
      check("R6 R7 after fall", reg_rdata, regval(en, fl, 1'b0));
      check("R9 irq after fall", {31'd0, irq_out}, {31'd0, |(fl & en)});
      // writing ones to the flags leaves them alone (R7)
      wr({26'd0, en, 3'b111});
      check("R7 write one no effect", reg_rdata, regval(en, fl, 1'b0));
      wr({26'd0, en, 3'b000});
      check("R7 clear by zero", reg_rdata, regval(en, 3'b000, 1'b0));
      check("R9 irq cleared", {31'd0, irq_out}, 32'd0);
    end

    // R11: bit 6 and reserved bits ignored, buffer non-empty
    wr(32'hFFFF_FFC0);
    check("R11 reserved write", reg_rdata, regval(3'b000, 3'b000, 1'b0));
    fifo_level = 5'd0;
    wait_cyc(1);
    wr(32'hFFFF_FF80);
    check("R11 empty bit write", reg_rdata, regval(3'b000, 3'b000, 1'b1));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule